// File: doc/BRIEF.md
# Up-Counting Timer Base with Buffered Divider and Repetition

This block is a 16-bit time base. A clock divider produces one counter step every (divider + 1) clock cycles. The counter climbs from zero to a programmed period and then wraps. Each wrap produces an overflow pulse.

A repetition counter thins these wraps into update events. Update events are the points where buffered settings take effect. One output-compare channel produces a PWM-style level from the counter and a compare value. That compare value is applied either at once or at the next update event.

Settings arrive through a single-cycle write port that selects one of six targets by a 3-bit code. An enable input starts and stops counting.

Top module: `tmr_base`

## Requirements
- R1: After reset the counter, divider, period, repetition, compare value and buffer-mode bit are all zero. `ovf_o`, `upd_o` and `cmp_o` are low.
- R2: While running, the counter rises by one on each step. On a step taken at or above the period (select code 2), it returns to 0. `ovf_o` is high for exactly the one cycle in which the counter shows that 0.
- R3: Steps occur once every (D+1) clock cycles, where D is the active divider. A divider write (select code 1) goes to a holding register and becomes active only at the next overflow.
- R4: The counter and the divider phase stay frozen while the period is 0 or `en` is low.
- R5: A repetition down-counter is decremented at each overflow. At an overflow where it already reads 0, `upd_o` pulses with `ovf_o` and the counter reloads from the repetition value (select code 3). `upd_o` never pulses without `ovf_o`.
- R6: `cmp_o` is high exactly while the counter is below the active compare value (select code 4). A compare value above the period keeps `cmp_o` high at all times.
- R7: Bit 0 of the mode target (select code 5) chooses the compare buffering. With 0, a written compare value is active on the next cycle. With 1, it stays pending until the next update event.
- R8: A counter write (select code 0) sets the counter on the next clock edge and restarts the divider phase at zero. It takes priority over a step in the same cycle, and no overflow is reported for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counting enable |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 3 | Target: 0 counter, 1 divider, 2 period, 3 repetition, 4 compare, 5 mode |
| wr_data | input | W | Write data |
| cnt_o | output | W | Current counter value |
| ovf_o | output | 1 | Overflow pulse |
| upd_o | output | 1 | Update-event pulse |
| cmp_o | output | 1 | Compare channel output |

## Verification
The hardest situation to reach is a divider phase that is part-way through when a counter write lands. The divider value is only active after an overflow, so the stimulus first runs one short period at divider 0 to load the new divider. It then writes the counter one cycle into the slower phase. The next step arriving a full (D+1) cycles later, rather than one cycle later, shows that the phase was cleared. Buffered compare values are reached similarly: the value is written before the first overflow, then `cmp_o` is watched across that update.

// File: rtl/tmr_base.sv
module tmr_base #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         upd_o,
  output logic         cmp_o
);
  localparam logic [2:0] SEL_CNT = 3'd0;
  localparam logic [2:0] SEL_DIV = 3'd1;
  localparam logic [2:0] SEL_PER = 3'd2;
  localparam logic [2:0] SEL_REP = 3'd3;
  localparam logic [2:0] SEL_CMP = 3'd4;
  localparam logic [2:0] SEL_MOD = 3'd5;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, psc_q, div_pre, div_act, per_q, rep_q, rep_cnt, cmp_pre, cmp_act;
  logic         buf_q, ovf_q, upd_q;

  wire cwr  = wr_en && wr_sel == SEL_CNT;
  wire run  = en && per_q != ZERO;
  wire tick = run && psc_q == div_act;
  wire wrap = tick && cnt_q >= per_q && !cwr;
  wire fire = wrap && rep_cnt == ZERO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= ZERO;
      psc_q   <= ZERO;
      div_pre <= ZERO;
      div_act <= ZERO;
      per_q   <= ZERO;
      rep_q   <= ZERO;
      rep_cnt <= ZERO;
      cmp_pre <= ZERO;
      cmp_act <= ZERO;
      buf_q   <= 1'b0;
      ovf_q   <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      ovf_q <= wrap;
      upd_q <= fire;

      if (cwr) begin
        cnt_q <= wr_data;
        psc_q <= ZERO;
      end else if (run) begin
        psc_q <= tick ? ZERO : psc_q + ONE;
        if (tick) cnt_q <= wrap ? ZERO : cnt_q + ONE;
      end

      if (wrap) begin
        div_act <= div_pre;
        rep_cnt <= fire ? rep_q : rep_cnt - ONE;
      end

      if (wr_en) begin
        case (wr_sel)
          SEL_DIV: div_pre <= wr_data;
          SEL_PER: per_q   <= wr_data;
          SEL_REP: rep_q   <= wr_data;
          SEL_CMP: cmp_pre <= wr_data;
          SEL_MOD: buf_q   <= wr_data[0];
          default: ;
        endcase
      end

      if (wr_en && wr_sel == SEL_CMP && !buf_q) cmp_act <= wr_data;
      else if (fire)                            cmp_act <= cmp_pre;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign upd_o = upd_q;
  assign cmp_o = cnt_q < cmp_act;
endmodule

module tmr_base_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] cnt_o,
  input logic         ovf_o,
  input logic         upd_o,
  input logic [W-1:0] per_q,
  input logic [W-1:0] div_act,
  input logic [W-1:0] cmp_act,
  input logic         buf_q
);
  a_r2_ovf_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> cnt_o == '0);

  a_r3_div_loads_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act != $past(div_act)) |-> ovf_o);

  a_r4_zero_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0 && !wr_en) |=> $stable(cnt_o));

  a_r5_upd_with_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> ovf_o);

  a_r7_buffered_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act != $past(cmp_act) && $past(buf_q)) |-> upd_o);
endmodule

bind tmr_base tmr_base_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt_o(cnt_o), .ovf_o(ovf_o),
  .upd_o(upd_o), .per_q(per_q), .div_act(div_act), .cmp_act(cmp_act), .buf_q(buf_q)
);

// File: tb/tb_tmr_base.sv
module tb_tmr_base;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] cnt_o;
  logic        ovf_o, upd_o, cmp_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tmr_base #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_o(cnt_o), .ovf_o(ovf_o), .upd_o(upd_o), .cmp_o(cmp_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    en = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 cnt", cnt_o, 0);
    check("R1 ovf", ovf_o, 0);
    check("R1 upd", upd_o, 0);
    check("R1 cmp", cmp_o, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    wr(3'd2, 16'd4);
    en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      step();
      check("R2 cnt", cnt_o, i % 5);
      check("R2 ovf", ovf_o, int'(i % 5 == 0));
    end
  endtask

  task automatic t_divider();
    do_reset();
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd2);
    en = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      step();
      check("R3 cnt", cnt_o, (i <= 3) ? i : (i - 4) / 3);
    end
  endtask

  task automatic t_halt();
    do_reset();
    wr(3'd0, 16'd2);
    en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R4 period0 cnt", cnt_o, 2);
      check("R4 period0 ovf", ovf_o, 0);
    end
    wr(3'd2, 16'd5);
    step();
    check("R4 resume cnt", cnt_o, 3);
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R4 en low cnt", cnt_o, 3);
    end
  endtask

  task automatic t_repeat();
    do_reset();
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd2);
    en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      step();
      check("R5 ovf", ovf_o, int'(i % 2 == 0));
      check("R5 upd", upd_o, int'(i == 2 || i == 8));
    end
  endtask

  task automatic t_compare();
    do_reset();
    wr(3'd2, 16'd9);
    wr(3'd4, 16'd4);
    check("R6 cmp at 0", cmp_o, 1);
    en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      step();
      check("R6 cmp", cmp_o, int'((i % 10) < 4));
    end
    do_reset();
    wr(3'd2, 16'd3);
    wr(3'd4, 16'd10);
    en = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      step();
      check("R6 cmp above period", cmp_o, 1);
    end
  endtask

  task automatic t_buffered();
    do_reset();
    wr(3'd5, 16'd1);
    wr(3'd2, 16'd3);
    wr(3'd4, 16'd2);
    check("R7 pending cmp", cmp_o, 0);
    en = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      step();
      check("R7 cmp", cmp_o, (i < 4) ? 0 : int'((i % 4) < 2));
    end
  endtask

  task automatic t_cnt_write();
    do_reset();
    wr(3'd2, 16'd1);
    wr(3'd1, 16'd2);
    en = 1'b1;
    step(); step(); step();
    wr(3'd0, 16'd1);
    check("R8 loaded", cnt_o, 1);
    step(); step();
    check("R8 phase restart cnt", cnt_o, 1);
    check("R8 phase restart ovf", ovf_o, 0);
    step();
    check("R8 step after phase cnt", cnt_o, 0);
    check("R8 step after phase ovf", ovf_o, 1);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_wrap();
    t_divider();
    t_halt();
    t_repeat();
    t_compare();
    t_buffered();
    t_cnt_write();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule